// File: doc/BRIEF.md
# Short timestamp seconds extender

This block rebuilds a full time value from a compact 32-bit hardware timestamp. The compact word carries only the two lowest bits of the seconds count together with a 30-bit nanoseconds field. A wide reference seconds value, kept elsewhere and close to the true capture time, supplies the missing upper seconds.

The block measures how far the timestamp's two seconds bits sit from the reference's two low bits, modulo four. It reads a distance of three as one second in the past and reads zero, one or two as that many seconds ahead. It adds that signed offset to the reference. The nanoseconds pass through untouched.

A conversion starts when the input valid strobe is high. The timestamp and the reference are both captured on that clock edge, so the reference is read exactly once per conversion. The result appears one cycle later with its own valid strobe. If the reference is zero and the timestamp lies one second in the past, the seconds result stops at zero and an underflow flag is raised.

Top module: `ts_sec_extend`

## Requirements
- R1: While reset is low, and after it is released until the first conversion, out_valid, out_sec, out_nsec and out_underflow are all zero.
- R2: out_valid is high in exactly the cycle after each cycle in which in_valid is high, and low otherwise.
- R3: out_nsec equals bits 29:0 of the in_stamp captured with in_valid, unchanged.
- R4: The offset d is (in_stamp[31:30] minus ref_sec[1:0]) modulo 4. When d is 0, 1 or 2, out_sec equals ref_sec plus d.
- R5: When d is 3 and ref_sec is nonzero, out_sec equals ref_sec minus 1.
- R6: ref_sec is sampled only in the cycle in which in_valid is high. A change of ref_sec in any later cycle does not alter the result.
- R7: When d is 3 and ref_sec is 0, out_sec is 0 and out_underflow is 1. Every other conversion leaves out_underflow at 0.
- R8: While in_valid is low, out_sec, out_nsec and out_underflow hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Timestamp valid strobe |
| in_stamp | input | 32 | Compact timestamp: seconds low bits 31:30, nanoseconds 29:0 |
| ref_sec | input | 48 | Reference seconds |
| out_valid | output | 1 | Result valid strobe |
| out_sec | output | 48 | Extended seconds |
| out_nsec | output | 30 | Nanoseconds |
| out_underflow | output | 1 | Result was clamped at zero seconds |

## Verification
Every result is due one clock edge after the edge that captured in_valid. The bench drives inputs on falling edges. It changes ref_sec to an unrelated value right after the capture edge, and it reads the outputs on the following falling edge, after exactly one rising edge has passed. It then holds in_valid low for one more cycle and reads the outputs again, which checks that the strobe has dropped and the data is held. The sweep covers every two-bit seconds code against a set of references that includes zero, small values in every residue class, and large values.

// File: rtl/ts_sec_extend.sv
module ts_sec_extend #(
  parameter int SEC_W   = 48,
  parameter int STAMP_W = 32,
  parameter int SLO_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [STAMP_W-1:0] in_stamp,
  input  logic [SEC_W-1:0]   ref_sec,
  output logic               out_valid,
  output logic [SEC_W-1:0]   out_sec,
  output logic [STAMP_W-SLO_W-1:0] out_nsec,
  output logic               out_underflow
);
  localparam int NS_W = STAMP_W - SLO_W;

  logic [SLO_W-1:0] lo_in;
  logic [SLO_W-1:0] delta;
  logic             back;
  logic             at_zero;
  logic [SEC_W-1:0] fwd;
  logic [SEC_W-1:0] bwd;

  assign lo_in   = in_stamp[STAMP_W-1 -: SLO_W];
  assign delta   = lo_in - ref_sec[SLO_W-1:0];
  assign back    = &delta;
  assign at_zero = (ref_sec == '0);
  assign fwd     = ref_sec + SEC_W'(delta);
  assign bwd     = ref_sec - SEC_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_sec       <= '0;
      out_nsec      <= '0;
      out_underflow <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_nsec      <= in_stamp[NS_W-1:0];
        out_underflow <= back && at_zero;
        if (!back)        out_sec <= fwd;
        else if (at_zero) out_sec <= '0;
        else              out_sec <= bwd;
      end
    end
  end
endmodule

// File: rtl/ts_sec_extend_chk.sv
module ts_sec_extend_chk #(
  parameter int SEC_W   = 48,
  parameter int STAMP_W = 32,
  parameter int SLO_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [STAMP_W-1:0] in_stamp,
  input logic [SEC_W-1:0]   ref_sec,
  input logic               out_valid,
  input logic [SEC_W-1:0]   out_sec,
  input logic [STAMP_W-SLO_W-1:0] out_nsec,
  input logic               out_underflow
);
  localparam int NS_W = STAMP_W - SLO_W;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r3_nsec_pass: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_nsec == $past(in_stamp[NS_W-1:0]));
  a_r4_low_bits_match: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_underflow || out_sec[SLO_W-1:0] == $past(in_stamp[STAMP_W-1 -: SLO_W])));
  a_r6_ref_window: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_underflow || (out_sec - $past(ref_sec) + SEC_W'(1)) <= SEC_W'(3)));
  a_r7_clamp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_underflow |-> out_sec == '0);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_sec) && $stable(out_nsec) && $stable(out_underflow)));
endmodule

bind ts_sec_extend ts_sec_extend_chk #(.SEC_W(SEC_W), .STAMP_W(STAMP_W), .SLO_W(SLO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stamp(in_stamp),
  .ref_sec(ref_sec), .out_valid(out_valid), .out_sec(out_sec),
  .out_nsec(out_nsec), .out_underflow(out_underflow));

// File: tb/ts_sec_extend_test.sv
module ts_sec_extend_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [31:0] in_stamp = '0;
  logic [47:0] ref_sec = '0;
  logic        out_valid;
  logic [47:0] out_sec;
  logic [29:0] out_nsec;
  logic        out_underflow;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ts_sec_extend uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_stamp(in_stamp),
    .ref_sec(ref_sec), .out_valid(out_valid), .out_sec(out_sec),
    .out_nsec(out_nsec), .out_underflow(out_underflow));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [47:0] rf, input logic [1:0] s, input logic [29:0] ns);
    logic [1:0]  d;
    logic [47:0] es;
    logic        eu;
    d  = s - rf[1:0];
    eu = 1'b0;
    if (d == 2'd3) begin
      if (rf == 0) begin es = 0; eu = 1'b1; end
      else es = rf - 1;
    end else es = rf + 48'(d);
    @(negedge clk);
    in_valid = 1; in_stamp = {s, ns}; ref_sec = rf;
    @(negedge clk);
    in_valid = 0; ref_sec = ~rf; in_stamp = ~{s, ns};
    chk("R2 valid", 64'(out_valid), 64'd1);
    chk("R3 nsec", 64'(out_nsec), 64'(ns));
    if (d == 2'd3) chk(rf == 0 ? "R7 clamp sec" : "R5 back sec", 64'(out_sec), 64'(es));
    else chk("R4 fwd sec", 64'(out_sec), 64'(es));
    chk("R7 underflow", 64'(out_underflow), 64'(eu));
    @(negedge clk);
    chk("R2 valid low", 64'(out_valid), 64'd0);
    chk("R6 R8 hold sec", 64'(out_sec), 64'(es));
    chk("R8 hold nsec", 64'(out_nsec), 64'(ns));
    chk("R8 hold uf", 64'(out_underflow), 64'(eu));
  endtask

  initial begin
    logic [47:0] refs [12];
    refs = '{48'd0, 48'd1, 48'd2, 48'd3, 48'd4, 48'd5, 48'd6, 48'd7,
             48'd1000001, 48'h7FFF_FFFF_FFFE, 48'h1234_5678_9ABD, 48'hFFFF_FFFF_FFF0};
    repeat (2) @(negedge clk);
    chk("R1 valid", 64'(out_valid), 0);
    chk("R1 sec", 64'(out_sec), 0);
    chk("R1 nsec", 64'(out_nsec), 0);
    chk("R1 uf", 64'(out_underflow), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid post", 64'(out_valid), 0);
    chk("R1 sec post", 64'(out_sec), 0);
    for (int i = 0; i < 12; i++)
      for (int s = 0; s < 4; s++) begin
        convert(refs[i], 2'(s), 30'(i * 77777 + s * 250000000));
        convert(refs[i], 2'(s), 30'h3FFF_FFFF);
      end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule